// File: doc/BRIEF.md
# Peak Tracker with Low-Level Timeout

This block takes an unsigned sample stream, qualified by a valid strobe, and holds the largest sample accepted since the last reset. It also watches whether the stream has fallen below a reference. A select input chooses the reference: either the held peak itself or an external level word. When the low condition lasts a set number of clock cycles without a break, the block raises a stop flag and latches it. From then on the peak and the timer are frozen.

The timeout is a parameter in clock cycles. At a 4 MHz clock the default of 500,000,000 gives about two minutes. The counter width follows from the limit, so any limit up to 32 bits fits. The block never generates its own reset. Only the external reset input clears it, so a system that must restart after a stop routes the stop flag to the reset pin outside the block. That reset input is asserted asynchronously. It is released through a two-stage synchronizer.

Top module: `pkdrop_top`

## Requirements
- R1: While rst_ext is high, peak_out and stop_flag read 0 without waiting for a clock edge. After rst_ext falls, the first two rising edges still act as reset, so samples offered then are discarded. The third edge is the first one that works normally.
- R2: peak_out equals the largest smp_data accepted since reset, with 0 as the starting value. A sample is accepted on a rising edge where smp_vld is 1. A sample replaces the peak only when it is strictly greater. Data offered with smp_vld at 0 has no effect.
- R3: With ref_sel at 0 an accepted sample is low when it is strictly less than the peak held before that edge. With ref_sel at 1 it is low when it is strictly less than ref_level. A sample equal to the reference is not low.
- R4: The timeout counter adds one on every clock cycle while the most recent accepted sample was low. Edges with smp_vld at 0 keep counting when that last sample was low. An accepted sample that is not low sets the count back to 0.
- R5: stop_flag rises on the edge that completes LIMIT consecutive low cycles, and not one edge earlier.
- R6: Once stop_flag is 1 it stays 1, peak_out no longer changes whatever the inputs, and the counter stays saturated at LIMIT.
- R7: Only rst_ext clears stop_flag. After that reset, tracking and timing start again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_ext | input | 1 | External reset, active high, asserted asynchronously |
| smp_vld | input | 1 | Sample valid strobe |
| smp_data | input | DW | Unsigned sample word |
| ref_sel | input | 1 | Reference select: 0 uses the held peak, 1 uses ref_level |
| ref_level | input | DW | External reference word |
| peak_out | output | DW | Largest accepted sample |
| stop_flag | output | 1 | Latched timeout flag |

## Verification
The hardest situation to reach is a low run that is almost long enough. There are several variants of it:
- the run is cut one cycle before the limit by a sample exactly equal to the reference;
- the run is kept alive by cycles with no valid sample;
- the run ends at the limit in peak-compare mode, where the reference itself moves with the input.

To reach these in a short run, the bench builds the design with a limit of six cycles and four-bit data. It then sweeps every data value against every external level for a full limit. It also sweeps every ordered pair of samples for the peak function. Directed sequences place the breaking sample on the last cycle before the limit. A reference model advances in step with the design, so every cycle is compared.

// File: rtl/pkdrop_pkg.sv
package pkdrop_pkg;

  // Select the comparison reference: held peak or external level.
  function automatic logic [31:0] pick_ref(input logic sel,
                                           input logic [31:0] pk,
                                           input logic [31:0] ext);
    return sel ? ext : pk;
  endfunction

  // A sample is low when strictly under the reference.
  function automatic logic is_low(input logic [31:0] d, input logic [31:0] r);
    return d < r;
  endfunction

  // Saturating increment toward a limit.
  function automatic logic [31:0] sat_inc(input logic [31:0] c, input logic [31:0] lim);
    return (c >= lim) ? lim : c + 32'd1;
  endfunction

  // Replacement rule for the peak register.
  function automatic logic beats_peak(input logic [31:0] d, input logic [31:0] pk);
    return d > pk;
  endfunction

endpackage

// File: rtl/pkdrop_rst_sync.sv
module pkdrop_rst_sync (
  input  logic clk,
  input  logic rst_async,
  output logic rst_o
);
  logic stg1_q, stg2_q;

  // Asynchronous assert, release after two rising edges.
  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_o = ~stg2_q;
endmodule

// File: rtl/pkdrop_peak_hold.sv
module pkdrop_peak_hold #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] peak_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)          peak_q <= '0;
    else if (load_en) peak_q <= din;
  end
endmodule

// File: rtl/pkdrop_low_timer.sv
module pkdrop_low_timer
  import pkdrop_pkg::*;
#(
  parameter longint unsigned LIMIT = 500_000_000,
  parameter int              CW    = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic          below_now,
  output logic [CW-1:0] cnt_q,
  output logic          low_cyc,
  output logic          stop_q
);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic          below_q;
  logic [CW-1:0] cnt_nx;
  logic          hit_nx;

  // A cycle counts as low when the current sample is low, or when no
  // sample arrives and the last accepted one was low.
  assign low_cyc = smp_vld ? below_now : below_q;
  assign cnt_nx  = CW'(sat_inc(32'(cnt_q), 32'(LIM_C)));
  assign hit_nx  = low_cyc && (cnt_nx == LIM_C);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q   <= '0;
      below_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (!stop_q) begin
      if (smp_vld) below_q <= below_now;
      if (smp_vld && !below_now) cnt_q <= '0;
      else if (low_cyc)          cnt_q <= cnt_nx;
      if (hit_nx)                stop_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pkdrop_top.sv
module pkdrop_top
  import pkdrop_pkg::*;
#(
  parameter int              DW    = 12,
  parameter longint unsigned LIMIT = 500_000_000
) (
  input  logic          clk,
  input  logic          rst_ext,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp_data,
  input  logic          ref_sel,
  input  logic [DW-1:0] ref_level,
  output logic [DW-1:0] peak_out,
  output logic          stop_flag
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic          rst_i;
  logic [DW-1:0] peak_q;
  logic [DW-1:0] ref_w;
  logic          below_now;
  logic          load_en;
  logic [CW-1:0] cnt_q;
  logic          low_cyc;
  logic          stop_q;

  pkdrop_rst_sync u_rst (
    .clk       (clk),
    .rst_async (rst_ext),
    .rst_o     (rst_i)
  );

  assign ref_w     = DW'(pick_ref(ref_sel, 32'(peak_q), 32'(ref_level)));
  assign below_now = is_low(32'(smp_data), 32'(ref_w));
  assign load_en   = smp_vld && !stop_q && beats_peak(32'(smp_data), 32'(peak_q));

  pkdrop_peak_hold #(.DW(DW)) u_peak (
    .clk     (clk),
    .rst     (rst_i),
    .load_en (load_en),
    .din     (smp_data),
    .peak_q  (peak_q)
  );

  pkdrop_low_timer #(.LIMIT(LIMIT), .CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst_i),
    .smp_vld   (smp_vld),
    .below_now (below_now),
    .cnt_q     (cnt_q),
    .low_cyc   (low_cyc),
    .stop_q    (stop_q)
  );

  assign peak_out  = peak_q;
  assign stop_flag = stop_q;
endmodule

// File: rtl/pkdrop_chk.sv
module pkdrop_chk #(
  parameter int              DW    = 12,
  parameter int              CW    = 29,
  parameter longint unsigned LIMIT = 500_000_000
) (
  input logic          clk,
  input logic          rst_i,
  input logic          smp_vld,
  input logic          below_now,
  input logic [CW-1:0] cnt_q,
  input logic [DW-1:0] peak_out,
  input logic          stop_flag
);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  a_r6_stop_sticky: assert property (@(posedge clk) disable iff (rst_i)
    stop_flag |=> stop_flag);

  a_r6_peak_frozen: assert property (@(posedge clk) disable iff (rst_i)
    stop_flag |=> $stable(peak_out));

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst_i)
    cnt_q <= LIM_C);

  a_r2_peak_rises_only: assert property (@(posedge clk) disable iff (rst_i)
    !stop_flag |=> (peak_out >= $past(peak_out)));

  a_r5_stop_at_limit: assert property (@(posedge clk) disable iff (rst_i)
    $rose(stop_flag) |-> (cnt_q == LIM_C));

  a_r4_clear_on_high: assert property (@(posedge clk) disable iff (rst_i)
    (smp_vld && !below_now && !stop_flag) |=> (cnt_q == '0));

  a_r4_count_step: assert property (@(posedge clk) disable iff (rst_i)
    (smp_vld && below_now && !stop_flag && (cnt_q < LIM_C))
      |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));
endmodule

bind pkdrop_top pkdrop_chk #(.DW(DW), .CW(CW), .LIMIT(LIMIT)) u_chk (
  .clk       (clk),
  .rst_i     (rst_i),
  .smp_vld   (smp_vld),
  .below_now (below_now),
  .cnt_q     (cnt_q),
  .peak_out  (peak_out),
  .stop_flag (stop_flag)
);

// File: tb/pkdrop_top_tb_top.sv
module pkdrop_top_tb_top;
  localparam int DW  = 4;
  localparam int LIM = 6;

  logic          clk = 1'b0;
  logic          rst_ext = 1'b1;
  logic          smp_vld = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic          ref_sel = 1'b0;
  logic [DW-1:0] ref_level = '0;
  logic [DW-1:0] peak_out;
  logic          stop_flag;

  int n_chk = 0;
  int n_fail = 0;
  int m_peak, m_cnt;
  bit m_bq, m_stop;

  always #10 clk = ~clk;

  pkdrop_top #(.DW(DW), .LIMIT(LIM)) dut_i (
    .clk(clk), .rst_ext(rst_ext), .smp_vld(smp_vld), .smp_data(smp_data),
    .ref_sel(ref_sel), .ref_level(ref_level), .peak_out(peak_out),
    .stop_flag(stop_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp(input string tag);
    chk(tag, int'(peak_out), m_peak);
    chk(tag, int'(stop_flag), int'(m_stop));
  endtask

  // Reference model of one clock edge, written from the requirements.
  task automatic model_edge(input bit v, input int d);
    int  r;
    bit  low, lc;
    if (m_stop) return;
    r   = ref_sel ? int'(ref_level) : m_peak;
    low = (d < r);
    lc  = v ? low : m_bq;
    if (v) m_bq = low;
    if (v && !low) m_cnt = 0;
    else if (lc) begin
      m_cnt = (m_cnt >= LIM) ? LIM : m_cnt + 1;
      if (m_cnt == LIM) m_stop = 1;
    end
    if (v && d > m_peak) m_peak = d;
  endtask

  // Called at a falling edge: drive, let one rising edge pass, return at the next falling edge.
  task automatic step(input bit v, input int d, input string tag);
    smp_vld  = v;
    smp_data = DW'(d);
    @(posedge clk);
    model_edge(v, d);
    @(negedge clk);
    cmp(tag);
  endtask

  task automatic do_reset();
    smp_vld = 1'b0;
    rst_ext = 1'b1;
    #3;
    chk("R1", int'(peak_out), 0);
    chk("R1", int'(stop_flag), 0);
    @(negedge clk);
    rst_ext  = 1'b0;
    m_peak = 0; m_cnt = 0; m_bq = 0; m_stop = 0;
    smp_vld  = 1'b1;
    smp_data = DW'(9);
    @(negedge clk);
    chk("R1", int'(peak_out), 0);
    @(negedge clk);
    chk("R1", int'(peak_out), 0);
    smp_vld = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R2: every ordered pair of samples, peak compare mode
    ref_sel = 1'b0;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        do_reset();
        step(1, a, "R2");
        step(1, b, "R2");
      end
    end

    // R2: data without the valid strobe is ignored
    do_reset();
    step(1, 3, "R2");
    step(0, 15, "R2");
    step(0, 12, "R2");
    chk("R2", int'(peak_out), 3);

    // R3/R5: every data value against every external level for a full limit
    ref_sel = 1'b1;
    for (int lv = 0; lv < 16; lv++) begin
      for (int d = 0; d < 16; d++) begin
        ref_level = DW'(lv);
        do_reset();
        for (int k = 0; k < LIM; k++) step(1, d, "R3");
        chk("R5", int'(stop_flag), (d < lv) ? 1 : 0);
      end
    end

    // R4: idle cycles keep the count; equal sample one cycle before limit clears it
    ref_level = DW'(8);
    do_reset();
    step(1, 3, "R4");
    for (int k = 0; k < LIM - 2; k++) step(0, 15, "R4");
    step(1, 8, "R4");
    for (int k = 0; k < LIM - 1; k++) step(1, 2, "R4");
    chk("R4", int'(stop_flag), 0);
    step(1, 2, "R5");
    chk("R5", int'(stop_flag), 1);

    // R5/R6/R7: peak compare mode, stop then freeze then external restart
    ref_sel = 1'b0;
    do_reset();
    step(1, 7, "R3");
    for (int k = 0; k < LIM; k++) step(1, 7, "R3");
    chk("R3", int'(stop_flag), 0);
    step(1, 10, "R2");
    for (int k = 0; k < LIM - 1; k++) step(1, 2, "R5");
    chk("R5", int'(stop_flag), 0);
    step(1, 2, "R5");
    chk("R5", int'(stop_flag), 1);
    step(1, 15, "R6");
    step(1, 14, "R6");
    chk("R6", int'(peak_out), 10);
    for (int k = 0; k < 20; k++) step(0, 0, "R7");
    chk("R7", int'(stop_flag), 1);
    do_reset();
    chk("R7", int'(stop_flag), 0);
    step(1, 5, "R7");
    chk("R7", int'(peak_out), 5);

    // R1: asynchronous clear in the middle of a run
    step(1, 12, "R1");
    #3;
    rst_ext = 1'b1;
    #2;
    chk("R1", int'(peak_out), 0);
    @(negedge clk);
    do_reset();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule